// File: doc/BRIEF.md
# Iterative CORDIC Sine-Cosine Generator

This block turns one signed angle into its cosine and sine using a CORDIC rotator in rotation mode. The angle is a 16-bit signed fraction of a full turn, so a single word spans minus one turn to just under plus one turn. The block first wraps the angle into a half-turn window. It then mirrors any angle beyond a quarter turn back into the range where CORDIC converges and remembers that both results must be negated. It runs a fixed number of micro-rotations from a start vector that already carries the inverse CORDIC gain, so no final multiply is needed. A rounding and saturating stage produces the outputs.

A user drives an angle and pulses `start` for one cycle. Sixteen clock edges later `done` is high, `cos_q15` holds the cosine and `sin_q15` holds the sine. Both values stay put until the next start or reset. A start that arrives mid-computation discards the running work and begins again with the new angle.

Top module: `cordic_sincos`

## Requirements
- R1: `theta` is a signed Q0.15 fraction of a turn: 32768 LSBs equal 360°, so 0x2000 is 90° and 0x4000 is 180°. After a computation, `cos_q15` holds round(32768·cos θ) and `sin_q15` holds round(32768·sin θ), each within 6 LSBs, both as signed Q0.15.
- R2: Angles that differ by exactly one turn give bit-identical results, for negative and positive inputs alike.
- R3: The exact angles 0°, ±90°, ±180°, ±270° and −360° (0x8000) give the correct axis values, including the quarter-turn boundaries where the mirror fold applies.
- R4: Results are saturated to the range −32768…32767, so cos 0° reads 32767 rather than wrapping to a negative value.
- R5: `done` first reads high after the 15th rising edge that follows the edge sampling `start` high. That is one capture edge, 14 iteration edges and one output edge.
- R6: While `done` is high and `start` stays low, `done`, `cos_q15` and `sin_q15` do not change, even if `theta` changes.
- R7: A `start` during a running computation restarts it. The results belong to the new angle, and `done` rises 15 edges after the new start edge.
- R8: Synchronous active-high `rst` clears `done`, `cos_q15` and `sin_q15` to zero and abandons any running computation.
- R9: `done` is low in the cycle after `start` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Captures `theta` and begins a computation |
| theta | input | 16 | Signed angle, Q0.15 fraction of one turn |
| done | output | 1 | Results valid; held until next start or reset |
| cos_q15 | output | 16 | Cosine, signed Q0.15 |
| sin_q15 | output | 16 | Sine, signed Q0.15 |

## Verification
The bench builds the block with its default 14 iterations and 4 guard bits. The leftover angle error is then at most atan(2^-13) of a turn-fraction, which is about 4 LSB of output, so a 6 LSB tolerance against real-valued sine and cosine is meaningful. These defaults also let the bench check the latency at exactly 15 edges. The bench sweeps the whole 16-bit angle word, so every quadrant, both wrap directions and the saturation at +1.0 are exercised.

// File: rtl/sincos_pkg.sv
package sincos_pkg;
  localparam int ANG_W    = 16;                 // angle / result word, Q0.15
  localparam int GUARD    = 4;                  // extra fraction bits inside
  localparam int XW       = ANG_W + GUARD + 2;  // x/y datapath width
  localparam int ZW       = ANG_W + GUARD + 1;  // residual angle width
  localparam int MAX_ITER = 14;                 // size of the arctangent table
  localparam int QTURN    = 1 << (ANG_W - 3);   // 90 degrees in input LSBs

  // inverse CORDIC gain 0.6072529 scaled by 2^(15+GUARD)
  localparam logic signed [XW-1:0] INV_GAIN = XW'(318376);

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_EMIT} phase_t;

  // atan(2^-i) as a fraction of a turn, 2^(15+GUARD) LSBs per turn
  function automatic logic signed [ZW-1:0] atan_step(input int i);
    case (i)
      0:  return ZW'(65536);
      1:  return ZW'(38688);
      2:  return ZW'(20442);
      3:  return ZW'(10376);
      4:  return ZW'(5208);
      5:  return ZW'(2607);
      6:  return ZW'(1304);
      7:  return ZW'(652);
      8:  return ZW'(326);
      9:  return ZW'(163);
      10: return ZW'(81);
      11: return ZW'(41);
      12: return ZW'(20);
      13: return ZW'(10);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sincos_fold.sv
module sincos_fold
  import sincos_pkg::*;
(
  input  logic [ANG_W-1:0]     theta,
  output logic signed [ZW-1:0] z_init,
  output logic                 flip
);
  localparam int TOP = ANG_W - 2;   // msb of the half-turn window
  localparam int EXT = ZW - (ANG_W - 1) - GUARD;

  logic [TOP:0] wrapped;
  logic [TOP:0] folded;

  always_comb begin
    // dropping the top bit reduces modulo one turn into [-180, +180)
    wrapped = theta[TOP:0];
    // quadrant codes 01 and 10 lie beyond +/-90 degrees
    flip    = wrapped[TOP] ^ wrapped[TOP-1];
    // toggling the sign bit adds or subtracts 180 degrees in those quadrants
    folded  = flip ? {~wrapped[TOP], wrapped[TOP-1:0]} : wrapped;
    z_init  = {{EXT{folded[TOP]}}, folded, {GUARD{1'b0}}};
  end
endmodule

// File: rtl/sincos_ctrl.sv
module sincos_ctrl
  import sincos_pkg::*;
#(
  parameter int ITER = MAX_ITER,
  localparam int IW  = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          capture,
  output logic          step,
  output logic          emit,
  output logic [IW-1:0] idx,
  output logic          done
);
  phase_t phase;
  logic   rst_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      idx   <= '0;
      done  <= 1'b0;
    end else if (start) begin
      phase <= PH_RUN;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      case (phase)
        PH_RUN: begin
          if (idx == IW'(ITER - 1)) phase <= PH_EMIT;
          else                      idx   <= idx + 1'b1;
        end
        PH_EMIT: begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    capture = start;
    step    = (phase == PH_RUN) && !start;
    emit    = (phase == PH_EMIT) && !start;
  end

  always_ff @(posedge clk) rst_d <= rst;

  // R9: a sampled start withdraws done on the next edge
  assert_start_clears_done_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> !done);

  // R5: the iteration index never leaves the table
  assert_idx_range_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RUN) |-> (idx < IW'(ITER)));

  // R5: done only rises out of the output phase
  assert_done_source_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(phase == PH_EMIT));

  // R8: the first cycle out of reset is idle with done low
  always_ff @(posedge clk) begin
    if (!rst && rst_d) begin
      assert_reset_idle_R8: assert (!done && phase == PH_IDLE);
    end
  end

  initial begin
    assert_iter_fits_R5: assert (ITER >= 1 && ITER <= MAX_ITER);
  end
endmodule

// File: rtl/sincos_iter.sv
module sincos_iter
  import sincos_pkg::*;
#(
  parameter int ITER = MAX_ITER,
  localparam int IW  = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 capture,
  input  logic                 step,
  input  logic [IW-1:0]        idx,
  input  logic signed [ZW-1:0] z_init,
  input  logic                 flip_in,
  output logic signed [XW-1:0] x_acc,
  output logic signed [XW-1:0] y_acc,
  output logic                 flip_q
);
  localparam logic signed [ZW-1:0] Z_LIMIT = ZW'(QTURN << GUARD);

  logic signed [ZW-1:0] z_acc;
  logic signed [XW-1:0] x_sh, y_sh;
  logic signed [ZW-1:0] ang;
  logic                 go_ccw;

  always_comb begin
    x_sh   = x_acc >>> idx;
    y_sh   = y_acc >>> idx;
    ang    = atan_step(int'(idx));
    go_ccw = !z_acc[ZW-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_acc  <= '0;
      y_acc  <= '0;
      z_acc  <= '0;
      flip_q <= 1'b0;
    end else if (capture) begin
      x_acc  <= INV_GAIN;
      y_acc  <= '0;
      z_acc  <= z_init;
      flip_q <= flip_in;
    end else if (step) begin
      if (go_ccw) begin
        x_acc <= x_acc - y_sh;
        y_acc <= y_acc + x_sh;
        z_acc <= z_acc - ang;
      end else begin
        x_acc <= x_acc + y_sh;
        y_acc <= y_acc - x_sh;
        z_acc <= z_acc + ang;
      end
    end
  end

  // R3: the folded start angle lies inside the convergence window
  assert_fold_window_R3: assert property (@(posedge clk) disable iff (rst)
    capture |=> (z_acc <= Z_LIMIT && z_acc >= -Z_LIMIT));
endmodule

// File: rtl/sincos_out.sv
module sincos_out
  import sincos_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    emit,
  input  logic                    flip,
  input  logic signed [XW-1:0]    x_acc,
  input  logic signed [XW-1:0]    y_acc,
  output logic signed [ANG_W-1:0] cos_q,
  output logic signed [ANG_W-1:0] sin_q
);
  localparam logic signed [XW-1:0] HALF  = XW'(1 << (GUARD - 1));
  localparam logic signed [XW-1:0] S_MAX = XW'((1 << (ANG_W - 1)) - 1);
  localparam logic signed [XW-1:0] S_MIN = -XW'(1 << (ANG_W - 1));

  function automatic logic signed [ANG_W-1:0] shape(input logic signed [XW-1:0] v,
                                                    input logic neg);
    logic signed [XW-1:0] s, r;
    s = neg ? -v : v;
    r = (s + HALF) >>> GUARD;
    if (r > S_MAX)      return S_MAX[ANG_W-1:0];
    else if (r < S_MIN) return S_MIN[ANG_W-1:0];
    else                return r[ANG_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cos_q <= '0;
      sin_q <= '0;
    end else if (emit) begin
      cos_q <= shape(x_acc, flip);
      sin_q <= shape(y_acc, flip);
    end
  end
endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos
  import sincos_pkg::*;
#(
  parameter int ITER = MAX_ITER,
  localparam int IW  = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [ANG_W-1:0]        theta,
  output logic                    done,
  output logic signed [ANG_W-1:0] cos_q15,
  output logic signed [ANG_W-1:0] sin_q15
);
  logic                 capture, step, emit, flip_c, flip_q;
  logic [IW-1:0]        idx;
  logic signed [ZW-1:0] z_init;
  logic signed [XW-1:0] x_acc, y_acc;

  sincos_fold u_fold (
    .theta  (theta),
    .z_init (z_init),
    .flip   (flip_c)
  );

  sincos_ctrl #(.ITER(ITER)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .capture (capture),
    .step    (step),
    .emit    (emit),
    .idx     (idx),
    .done    (done)
  );

  sincos_iter #(.ITER(ITER)) u_iter (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .step    (step),
    .idx     (idx),
    .z_init  (z_init),
    .flip_in (flip_c),
    .x_acc   (x_acc),
    .y_acc   (y_acc),
    .flip_q  (flip_q)
  );

  sincos_out u_out (
    .clk   (clk),
    .rst   (rst),
    .emit  (emit),
    .flip  (flip_q),
    .x_acc (x_acc),
    .y_acc (y_acc),
    .cos_q (cos_q15),
    .sin_q (sin_q15)
  );

  // R6: finished results hold until the next start
  assert_hold_results_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(cos_q15) && $stable(sin_q15)));
endmodule

// File: tb/cordic_sincos_bench.sv
`timescale 1ns/1ps
module cordic_sincos_bench;
  localparam int TOL = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] theta = '0;
  logic        done;
  logic signed [15:0] cos_q15, sin_q15;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cordic_sincos u_cordic_sincos (
    .clk(clk), .rst(rst), .start(start), .theta(theta),
    .done(done), .cos_q15(cos_q15), .sin_q15(sin_q15)
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ideal(input int a, input bit want_sin);
    real rad, v;
    int r;
    rad = a * 2.0 * 3.14159265358979 / 32768.0;
    v = want_sin ? $sin(rad) : $cos(rad);
    r = int'(v * 32768.0);
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  // pulse start with an angle, wait for done; returns edges waited
  task automatic compute(input int a, output int lat);
    @(negedge clk);
    theta = 16'(a);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_angle(input string req, input int a);
    int lat, ec, es, dc, ds;
    compute(a, lat);
    ec = ideal(a, 1'b0);
    es = ideal(a, 1'b1);
    dc = int'(cos_q15) - ec;
    ds = int'(sin_q15) - es;
    chk({req, " cos"}, done && dc <= TOL && dc >= -TOL, int'(cos_q15), ec);
    chk({req, " sin"}, done && ds <= TOL && ds >= -TOL, int'(sin_q15), es);
  endtask

  task automatic t_reset;   // R8
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset done", done == 1'b0, done, 0);
    chk("R8 reset cos", cos_q15 == 0, cos_q15, 0);
    chk("R8 reset sin", sin_q15 == 0, sin_q15, 0);
  endtask

  task automatic t_axes;    // R3, R4
    int lat;
    check_angle("R3 0deg", 0);
    check_angle("R3 +90deg", 16'sh2000);
    check_angle("R3 -90deg", -8192);
    check_angle("R3 +180deg", 16384);
    check_angle("R3 -180deg", -16384);
    check_angle("R3 +270deg", 24576);
    check_angle("R3 -270deg", -24576);
    check_angle("R3 -360deg", -32768);
    check_angle("R3 near +360deg", 32767);
    compute(0, lat);
    chk("R4 cos0 saturates", cos_q15 == 16'sd32767, cos_q15, 32767);
    compute(-32768, lat);
    chk("R4 cos-360 saturates", cos_q15 == 16'sd32767, cos_q15, 32767);
  endtask

  task automatic t_sweep;   // R1
    for (int k = 0; k < 60; k++) begin
      check_angle("R1 sweep", -32768 + k * 1111);
    end
  endtask

  task automatic t_wrap;    // R2
    int lat, c0, s0;
    for (int k = 0; k < 5; k++) begin
      int a = 1234 + k * 6007;
      compute(a, lat);
      c0 = cos_q15; s0 = sin_q15;
      compute(a - 32768, lat);
      chk("R2 wrap cos", cos_q15 == 16'(c0), cos_q15, c0);
      chk("R2 wrap sin", sin_q15 == 16'(s0), sin_q15, s0);
    end
  endtask

  task automatic t_latency; // R5, R9
    int lat;
    @(negedge clk);
    theta = 16'd3000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 done low after start", done == 1'b0, done, 0);
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk("R5 latency", lat == 15, lat, 15);
  endtask

  task automatic t_hold;    // R6
    int lat, c0, s0;
    compute(5000, lat);
    c0 = cos_q15; s0 = sin_q15;
    theta = 16'd12000;
    repeat (12) @(negedge clk);
    chk("R6 done held", done == 1'b1, done, 1);
    chk("R6 cos held", cos_q15 == 16'(c0), cos_q15, c0);
    chk("R6 sin held", sin_q15 == 16'(s0), sin_q15, s0);
  endtask

  task automatic t_restart; // R7
    int lat, dc, ds, ec, es;
    @(negedge clk);
    theta = 16'd7000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    compute(-11000, lat);
    chk("R7 restart latency", lat == 15, lat, 15);
    ec = ideal(-11000, 1'b0);
    es = ideal(-11000, 1'b1);
    dc = int'(cos_q15) - ec;
    ds = int'(sin_q15) - es;
    chk("R7 restart cos", dc <= TOL && dc >= -TOL, cos_q15, ec);
    chk("R7 restart sin", ds <= TOL && ds >= -TOL, sin_q15, es);
  endtask

  task automatic t_reset_mid; // R8
    int seen;
    @(negedge clk);
    theta = 16'd4000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 mid reset cos", cos_q15 == 0, cos_q15, 0);
    chk("R8 mid reset sin", sin_q15 == 0, sin_q15, 0);
    seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (done) seen++;
    end
    chk("R8 abandoned run stays idle", seen == 0, seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_axes();
    t_sweep();
    t_wrap();
    t_latency();
    t_hold();
    t_restart();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule